// File: doc/BRIEF.md
# Display Data Channel Memory Target

This block is a two-wire serial bus target that presents a byte-addressable memory at the display data channel device address. The device address is 7'h50, so the address byte A0h opens a write and A1h opens a read. SCL and SDA arrive as plain inputs. The block pulls SDA low through an open-drain enable output. Both lines are brought into the system clock domain through flop synchronizers, and bus conditions are then decoded from their edges.

A write transfer carries an 8-bit word offset followed by any number of data bytes. Each data byte is stored at the current offset, and the offset then advances. A read transfer streams bytes from the current offset for as long as the master acknowledges them. A random read works as follows: the master writes the offset, issues a repeated START, and then sends the read address. The offset always wraps within one 256-byte segment.

Storage is two 256-byte banks. A bank-select input, driven by an external configuration bit, chooses which bank appears as segment 00h.

Top module: `ddc_mem_target`

## Requirements
- R1: Out of reset, and before any START has been seen, `sda_oe_o` is 0, and whole bytes clocked on the bus draw no acknowledge.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Bytes clocked after the STOP and before a new START draw no acknowledge.
- R3: After a START, an address byte whose upper seven bits equal 7'h50 is acknowledged. The block holds SDA low for the whole ninth SCL clock. Bit 0 of the address byte selects read (1) or write (0).
- R4: `sda_oe_o` changes only while SCL is low. Master data is taken on the rising edge of SCL.
- R5: In a write, the first byte after the address sets the word offset. Each following byte is stored at the offset, after which the offset increments. Every received byte is acknowledged.
- R6: The word offset wraps from FFh to 00h inside the same bank, for both writes and reads.
- R7: An address byte whose upper seven bits differ from 7'h50 gets no acknowledge. The block keeps SDA released until the next START or STOP.
- R8: The offset set by a write survives a repeated START. The following read therefore begins at that offset.
- R9: In a read, each byte is sent MSB first. A master ACK (SDA low during the ninth clock) makes the block send the byte at the next offset.
- R10: A master NACK ends transmission. SDA then stays released, even while further clocks arrive, until a START or STOP.
- R11: With `bank_sel_i`=0 the segment maps to the lower bank, and with `bank_sel_i`=1 to the upper bank. The two banks hold independent contents.
- R12: A START in the middle of a byte abandons that byte without storing it and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| bank_sel_i | input | 1 | Selects the lower (0) or upper (1) bank for segment 00h |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Each bus edge takes two synchronizer stages plus one edge-history register before the controller sees it. The controller's registered output then moves `sda_oe_o` about three system clocks after SCL falls. The bench therefore keeps SCL low for at least twelve clocks before each rising edge. It samples SDA, whether an acknowledge or a data bit, four clocks into the following high phase, when every path has settled. Memory effects are checked only through later read transfers on the bus, one whole byte period after the write has landed. A monitor compares `sda_oe_o` across consecutive clocks while SCL is high and counts any movement there.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    localparam int BYTE_W = 8;
    localparam int OFFS_W = 8;
    localparam int BANK_W = 1;
    localparam int BIT_CNT_W = 4;
    localparam logic [6:0] DDC_DEV_ADDR = 7'h50;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } ctrl_state_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_OFFS,
        RX_DATA
    } rx_kind_e;

    // Bus events decoded in the system clock domain
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [OFFS_W-1:0] offs;
        logic [BYTE_W-1:0] data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic logic [OFFS_W-1:0] offs_next(input logic [OFFS_W-1:0] o);
        return o + OFFS_W'(1);
    endfunction

endpackage

// File: rtl/ddc_bus_sync.sv
module ddc_bus_sync
    import ddc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_lvl_o,
    output bus_ev_t ev_o
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    // Idle bus is high on both lines
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    assign scl_lvl_o = scl_s;

endmodule

// File: rtl/ddc_bank_mem.sv
module ddc_bank_mem
    import ddc_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int OW = OFFS_W,
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] bank,
    input  wr_req_t       wr,
    input  logic [OW-1:0] rd_offs,
    output logic [DW-1:0] rd_data
);

    localparam int AW    = BW + OW;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr.en) begin
            cells[{bank, wr.offs}] <= wr.data;
        end
    end

    assign rd_data = cells[{bank, rd_offs}];

endmodule

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
    import ddc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = DDC_DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rd_data,
    output wr_req_t           wr_o,
    output logic [OFFS_W-1:0] offs_o,
    output logic              sda_oe_o,
    output ctrl_state_e       st_o
);

    ctrl_state_e          st;
    rx_kind_e             kind;
    logic [BIT_CNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]    shreg;
    logic [OFFS_W-1:0]    offs;
    logic                 is_read;
    logic                 mack;
    logic                 oe;
    wr_req_t              wr;

    localparam logic [BIT_CNT_W-1:0] LAST_RX = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_TX = BIT_CNT_W'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind    <= RX_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            offs    <= '0;
            is_read <= 1'b0;
            mack    <= 1'b0;
            oe      <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                st <= ST_IDLE;
                oe <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_RX;
                kind   <= RX_ADDR;
                bitcnt <= '0;
                oe     <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (ev.scl_rise && bitcnt < LAST_RX) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + BIT_CNT_W'(1);
                        end else if (ev.scl_fall && bitcnt == LAST_RX) begin
                            unique case (kind)
                                RX_ADDR: begin
                                    if (addr_hit(shreg, DEV_ADDR)) begin
                                        is_read <= shreg[0];
                                        oe      <= 1'b1;
                                        st      <= ST_RX_ACK;
                                    end else begin
                                        st <= ST_WAIT;
                                    end
                                end
                                RX_OFFS: begin
                                    offs <= shreg;
                                    oe   <= 1'b1;
                                    st   <= ST_RX_ACK;
                                end
                                default: begin
                                    wr.en   <= 1'b1;
                                    wr.offs <= offs;
                                    wr.data <= shreg;
                                    offs    <= offs_next(offs);
                                    oe      <= 1'b1;
                                    st      <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (kind == RX_ADDR && is_read) begin
                                shreg <= rd_data;
                                oe    <= ~rd_data[BYTE_W-1];
                                st    <= ST_TX;
                            end else begin
                                oe   <= 1'b0;
                                st   <= ST_RX;
                                kind <= (kind == RX_ADDR) ? RX_OFFS : RX_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == LAST_TX) begin
                                oe     <= 1'b0;
                                offs   <= offs_next(offs);
                                bitcnt <= '0;
                                st     <= ST_TX_ACK;
                            end else begin
                                oe     <= ~shreg[BYTE_W-2];
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                bitcnt <= bitcnt + BIT_CNT_W'(1);
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                shreg <= rd_data;
                                oe    <= ~rd_data[BYTE_W-1];
                                st    <= ST_TX;
                            end else begin
                                oe <= 1'b0;
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: begin
                        oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign wr_o     = wr;
    assign offs_o   = offs;
    assign sda_oe_o = oe;
    assign st_o     = st;

endmodule

// File: rtl/ddc_mem_target.sv
module ddc_mem_target
    import ddc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = DDC_DEV_ADDR,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic bank_sel_i,
    output logic sda_oe_o
);

    bus_ev_t           bus_ev;
    logic              scl_lvl;
    wr_req_t           wr_req;
    logic [OFFS_W-1:0] cur_offs;
    logic [BYTE_W-1:0] rd_byte;
    ctrl_state_e       ctrl_st;

    ddc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl_o(scl_lvl),
        .ev_o     (bus_ev)
    );

    ddc_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev      (bus_ev),
        .rd_data (rd_byte),
        .wr_o    (wr_req),
        .offs_o  (cur_offs),
        .sda_oe_o(sda_oe_o),
        .st_o    (ctrl_st)
    );

    ddc_bank_mem #(.DW(BYTE_W), .OW(OFFS_W), .BW(BANK_W)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .bank   (bank_sel_i),
        .wr     (wr_req),
        .rd_offs(cur_offs),
        .rd_data(rd_byte)
    );

endmodule

// File: rtl/ddc_mem_target_chk.sv
module ddc_mem_target_chk
    import ddc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        scl_lvl,
    input bus_ev_t     ev,
    input ctrl_state_e st,
    input logic        sda_oe
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        st == ST_IDLE |-> !sda_oe); // R1

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (st == ST_IDLE && !sda_oe)); // R2

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_lvl); // R4

    AST_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (rst)
        st == ST_WAIT |-> !sda_oe); // R7

    AST_START_REARMS: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_RX && !sda_oe)); // R12

endmodule

bind ddc_mem_target ddc_mem_target_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .scl_lvl(scl_lvl),
    .ev     (bus_ev),
    .st     (ctrl_st),
    .sda_oe (sda_oe_o)
);

// File: tb/ddc_mem_target_tb_top.sv
module ddc_mem_target_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic bank_sel = 1'b0;
    logic sda_oe;
    wire  sda_line;

    assign sda_line = m_sda & ~sda_oe;

    always #10 clk = ~clk;

    ddc_mem_target dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .bank_sel_i(bank_sel),
        .sda_oe_o  (sda_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] exp_mem [2][256];

    // Monitor: SDA enable movement during SCL high, and any assertion of it
    logic prev_scl = 1'b1;
    logic prev_oe  = 1'b0;
    int   oe_high_moves = 0;
    bit   oe_seen = 1'b0;
    always @(posedge clk) begin
        if (!rst && scl && prev_scl && sda_oe !== prev_oe) oe_high_moves++;
        if (sda_oe) oe_seen = 1'b1;
        prev_scl = scl;
        prev_oe  = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(6);
        scl = 1'b1;   tick(8);
        m_sda = 1'b0; tick(8);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(4);
        m_sda = 1'b0; tick(6);
        scl = 1'b1;   tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_bit(input logic b);
        tick(6);
        m_sda = b; tick(6);
        scl = 1'b1; tick(8);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(6);
        m_sda = 1'b1; tick(6);
        scl = 1'b1; tick(4);
        ack = ~sda_line; tick(4);
        scl = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(12);
            scl = 1'b1; tick(4);
            b = {b[6:0], sda_line}; tick(4);
            scl = 1'b0;
        end
        tick(6);
        m_sda = ~give_ack; tick(6);
        scl = 1'b1; tick(8);
        scl = 1'b0; tick(1);
        m_sda = 1'b1; tick(5);
    endtask

    task automatic do_write(input logic [7:0] offs, input logic [7:0] d0,
                            input logic [7:0] d1, input logic [7:0] d2, input int n);
        logic ack;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(8'hA0, ack); check("R3 write address ack", ack, 1);
        send_byte(offs, ack);  check("R5 offset ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack); check("R5 data ack", ack, 1);
            exp_mem[bank_sel][8'(offs + i)] = d[i];
        end
        bus_stop();
        check("R2 released after stop", sda_oe, 0);
    endtask

    task automatic do_read(input logic [7:0] offs, input int n, input string tag);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA0, ack); check("R3 address ack", ack, 1);
        send_byte(offs, ack);  check("R5 offset ack", ack, 1);
        bus_start();
        send_byte(8'hA1, ack); check("R3 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            check(tag, b, exp_mem[bank_sel][8'(offs + i)]);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        logic ack;
        check("R1 reset release", sda_oe, 0);
        scl = 1'b0; tick(6);
        oe_seen = 1'b0;
        send_byte(8'hA0, ack);
        check("R1 no ack before start", ack, 0);
        check("R1 no drive before start", oe_seen, 0);
        bus_stop();
    endtask

    task automatic t_write_read();
        do_write(8'h10, 8'hAA, 8'hBB, 8'hCC, 3);
        do_write(8'h40, 8'h77, 8'h00, 8'h00, 1);
        do_read(8'h10, 3, "R8 R9 random then sequential read");
        do_read(8'h11, 1, "R8 random read single");
    endtask

    task automatic t_wrap();
        do_write(8'hFE, 8'h11, 8'h22, 8'h33, 3);
        check("R6 write wrapped into 00h", exp_mem[0][0], 8'h33);
        do_read(8'hFE, 3, "R6 read wraps FFh to 00h");
    endtask

    task automatic t_nack();
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA0, ack); check("R3 address ack", ack, 1);
        send_byte(8'h10, ack); check("R5 offset ack", ack, 1);
        bus_start();
        send_byte(8'hA1, ack); check("R3 read address ack", ack, 1);
        recv_byte(b, 1'b0);    check("R9 first byte", b, 8'hAA);
        oe_seen = 1'b0;
        recv_byte(b, 1'b0);
        check("R10 bus idle after nack", b, 8'hFF);
        check("R10 no drive after nack", oe_seen, 0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic ack;
        bus_start();
        send_byte(8'hA4, ack); check("R7 foreign address nack", ack, 0);
        oe_seen = 1'b0;
        send_byte(8'h00, ack);
        check("R7 following byte nack", ack, 0);
        check("R7 no drive after mismatch", oe_seen, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA1, ack); check("R7 next start answered", ack, 1);
        bus_stop();
    endtask

    task automatic t_stop();
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); check("R3 address ack", ack, 1);
        bus_stop();
        check("R2 stop releases", sda_oe, 0);
        scl = 1'b0; tick(6);
        send_byte(8'hA0, ack);
        check("R2 ignored after stop", ack, 0);
        bus_stop();
    endtask

    task automatic t_bank();
        bank_sel = 1'b1;
        do_write(8'h10, 8'h5A, 8'h00, 8'h00, 1);
        do_read(8'h10, 1, "R11 upper bank read");
        bank_sel = 1'b0;
        do_read(8'h10, 1, "R11 lower bank untouched");
    endtask

    task automatic t_abort();
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hA0, ack); check("R3 address ack", ack, 1);
        send_byte(8'h40, ack); check("R5 offset ack", ack, 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        send_byte(8'hA1, ack); check("R12 restart address ack", ack, 1);
        recv_byte(b, 1'b0);
        check("R12 partial byte not stored", b, 8'h77);
        bus_stop();
    endtask

    initial begin
        for (int k = 0; k < 2; k++)
            for (int a = 0; a < 256; a++) exp_mem[k][a] = 8'h00;
        tick(5);
        check("R1 released in reset", sda_oe, 0);
        rst = 1'b0;
        tick(4);
        t_reset();
        t_write_read();
        t_wrap();
        t_nack();
        t_mismatch();
        t_stop();
        t_bank();
        t_abort();
        check("R4 enable moved while SCL high", oe_high_moves, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule